// File: doc/BRIEF.md
# Prescaled Eight-Bit Event Timer

This block is an up-counting timer/counter for a small controller. It counts one of two sources. The first is an internal instruction tick that fires once every `INSTR_DIV` system clocks. The second is an external pin, which is synchronized and edge-detected. The chosen source can go straight to the counter, or it can first pass through a power-of-two prescaler. When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears that flag with an explicit strobe.

Software times an interval in four steps. It picks the source, the edge and the divide ratio through a 6-bit configuration register. It preloads the count register with N. It clears the flag. It then waits for the flag to return, which happens after 256 − N prescaled ticks. Loading the count register also restarts the hidden prescaler count, so each interval starts from a clean prescaler phase. An interrupt output is high while both the flag and an enable input are high.

Top module: `prescaled_timer`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0x00, the overflow flag reads 0, the prescaler count is zero and the configuration reads 0x3F.
- R2: The count increases by exactly one on each prescaled tick, wraps from 0xFF to 0x00, and holds its value in every other cycle.
- R3: The overflow flag becomes 1 in the cycle after the wrap from 0xFF to 0x00. It then stays 1 until `flag_clr` is applied. If a wrap and a clear occur in the same cycle, the flag ends up set.
- R4: Configuration bit 3 = 1 bypasses the prescaler, so there is one tick per source event. With bit 3 = 0, the ratio is one tick per 2^(code+1) source events, where code is bits 2:0. Code 0 gives 1:2 and code 7 gives 1:256.
- R5: Configuration bit 5 selects the source. A value of 0 selects the internal tick, which fires once every `INSTR_DIV` clocks. A value of 1 selects the external pin.
- R6: Configuration bit 4 selects the external edge. A value of 0 selects low-to-high and a value of 1 selects high-to-low. The pin passes through two synchronizer flops. In bypass mode, a pin change set up before clock edge k shows in the count after edge k+2, and not before.
- R7: A write to the count register loads `cnt_wdata` on the next edge. The write takes priority over a tick arriving in the same cycle. It resets the prescaler count to zero and leaves the configuration unchanged.
- R8: After a preload of N, the flag sets after exactly 256 − N prescaled ticks.
- R9: `irq` is 1 exactly when the overflow flag and `irq_en` are both 1.
- R10: A configuration write appears on `cfg_q` after the next edge. If a lower ratio is chosen while the prescaler count is at or above the new limit, the next source event produces a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_in | input | 1 | External count pin (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_q | output | 6 | Configuration readback |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count preload value |
| cnt_q | output | CNT_W | Count readback |
| flag_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CNT_W` = 8 and `INSTR_DIV` = 3. The odd internal period means the divider phase never lines up with the 2^k prescaler ratios, so phase slips between the two are exposed. The short period also brings a full 1:256 interval and a complete 256-tick wrap within a few thousand cycles. A behavioural model is compared against the design on every clock. It is run against both edges of the external pin, against a flag clear held high across an overflow, and against count writes made in the middle of a prescale period.

// File: rtl/tmr8_pkg.sv
// Package: shared configuration layout for the prescaled timer.
// Assumes a 3-bit prescaler code, so the largest ratio is 1:256.
package tmr8_pkg;
    localparam int PS_SEL_W = 3;
    localparam int CFG_W    = 3 + PS_SEL_W;

    typedef struct packed {
        logic                ext_src;    // 1 = external pin, 0 = internal tick
        logic                fall_edge;  // 1 = high-to-low, 0 = low-to-high
        logic                ps_bypass;  // 1 = prescaler skipped
        logic [PS_SEL_W-1:0] ps_code;    // ratio 2^(code+1)
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_clk_src.sv
// Module: source selection for the timer.
// It produces a one-cycle source tick, either from the internal
// instruction divider or from a synchronized, edge-detected external pin.
// Assumes ext_in is asynchronous to clk and each of its levels lasts at
// least two clock periods.
module tmr_clk_src #(
    parameter int INSTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic ext_src,
    input  logic fall_edge,
    output logic src_tick
);
    localparam int DIV_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;

    logic       sync1, sync2, sync3;
    logic       ext_rise, ext_fall, ext_tick;
    logic       int_tick;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= ext_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    // Edge detection on the synchronized pin.
    always_comb begin
        ext_rise = sync2 & ~sync3;
        ext_fall = ~sync2 & sync3;
        ext_tick = fall_edge ? ext_fall : ext_rise;
    end

    generate
        if (INSTR_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_cnt;

            // Free-running instruction-clock divider.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_cnt <= '0;
                else if (div_cnt == DIV_W'(INSTR_DIV - 1))
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + DIV_W'(1);
            end

            assign int_tick = (div_cnt == DIV_W'(INSTR_DIV - 1));

            a_r5_int_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                int_tick |=> !int_tick);
        end else begin : g_nodiv
            assign int_tick = 1'b1;
        end
    endgenerate

    // Source multiplexer.
    always_comb src_tick = ext_src ? ext_tick : int_tick;

    a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
    a_r6_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall);
endmodule

// File: rtl/tmr_prescale.sv
// Module: power-of-two prescaler.
// Divides source ticks by 2^(code+1), or passes them straight through
// when bypassed. A count-register write resets the hidden count.
// The limit test uses >=, so a ratio lowered mid-count cannot stall.
module tmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             bypass,
    input  logic [SEL_W-1:0] code,
    input  logic             restart,
    output logic             ps_tick
);
    localparam int PS_W = 1 << SEL_W;

    logic [PS_W-1:0] ps_cnt;
    logic [SEL_W:0]  shamt;
    logic [PS_W:0]   limit;
    logic            at_lim;

    // Ratio limit derived from the code: 2^(code+1) - 1.
    always_comb begin
        shamt   = {1'b0, code} + (SEL_W + 1)'(1);
        limit   = ({{PS_W{1'b0}}, 1'b1} << shamt) - (PS_W + 1)'(1);
        at_lim  = ({1'b0, ps_cnt} >= limit);
        ps_tick = src_tick & (bypass | at_lim);
    end

    // Hidden prescaler count, cleared by reset and by count writes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            ps_cnt <= '0;
        else if (src_tick && !bypass)
            ps_cnt <= at_lim ? '0 : ps_cnt + PS_W'(1);
    end

    a_r7_ps_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ps_cnt == '0);
    a_r4_ps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (!src_tick || bypass)) |=> $stable(ps_cnt));
endmodule

// File: rtl/tmr_count_core.sv
// Module: count register and sticky overflow flag.
// Loads on a write, otherwise steps on each prescaled tick. A wrap from
// all ones sets the flag, and the set wins over a clear in the same cycle.
module tmr_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic ovf;

    // A wrap occurs only on an accepted tick at all ones.
    always_comb ovf = tick & ~cnt_we & (&cnt);

    // Count register: a write has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_we)
            cnt <= cnt_wdata;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end

    // Sticky overflow flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (ovf)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> cnt == $past(cnt) + CNT_W'(1));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(cnt));
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt == $past(cnt_wdata));
    a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/prescaled_timer.sv
// Module: top of the prescaled event timer.
// Holds the configuration register and wires source selection, the
// prescaler and the count core together. Reset selects the external pin,
// the falling edge and the prescaler bypass.
module prescaled_timer #(
    parameter int CNT_W     = 8,
    parameter int INSTR_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ext_in,
    input  logic                      cfg_we,
    input  logic [tmr8_pkg::CFG_W-1:0] cfg_wdata,
    output logic [tmr8_pkg::CFG_W-1:0] cfg_q,
    input  logic                      cnt_we,
    input  logic [CNT_W-1:0]          cnt_wdata,
    output logic [CNT_W-1:0]          cnt_q,
    input  logic                      flag_clr,
    output logic                      ovf_flag,
    input  logic                      irq_en,
    output logic                      irq
);
    import tmr8_pkg::*;

    tmr_cfg_t cfg;
    logic     src_tick;
    logic     ps_tick;

    // Configuration register, all ones at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '1;
        else if (cfg_we)
            cfg <= tmr_cfg_t'(cfg_wdata);
    end

    tmr_clk_src #(.INSTR_DIV(INSTR_DIV)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .ext_src   (cfg.ext_src),
        .fall_edge (cfg.fall_edge),
        .src_tick  (src_tick)
    );

    tmr_prescale #(.SEL_W(PS_SEL_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .bypass   (cfg.ps_bypass),
        .code     (cfg.ps_code),
        .restart  (cnt_we),
        .ps_tick  (ps_tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ps_tick),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .flag_clr  (flag_clr),
        .cnt       (cnt_q),
        .flag      (ovf_flag)
    );

    // Readback and interrupt request.
    always_comb begin
        cfg_q = CFG_W'(cfg);
        irq   = ovf_flag & irq_en;
    end

    a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_q == $past(cfg_wdata));
    a_r7_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

// File: tb/tb_prescaled_timer.sv
// Bench: a behavioural reference model is compared on every clock, and
// direct checks are made on the boundary cases.
module tb_prescaled_timer;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_q;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_q;
    logic       flag_clr = 1'b0;
    logic       ovf_flag;
    logic       irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    prescaled_timer #(.CNT_W(8), .INSTR_DIV(D)) dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .flag_clr(flag_clr), .ovf_flag(ovf_flag),
        .irq_en(irq_en), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model state.
    int  m_cnt, m_ps, m_div, m_cfg;
    bit  m_flag, m_s1, m_s2, m_s3, m_valid;

    always @(posedge clk) begin
        int ratio;
        bit st, pt, ovf;
        if (!rst_n) begin
            m_cnt = 0; m_ps = 0; m_div = 0; m_cfg = 63; m_flag = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            if (m_cfg[5])
                st = m_cfg[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
            else
                st = (m_div == D - 1);
            ratio = 1 << ((m_cfg & 7) + 1);
            pt = st && (m_cfg[3] || m_ps >= ratio - 1);
            ovf = !cnt_we && pt && (m_cnt == 255);
            if (cnt_we) m_ps = 0;
            else if (st && !m_cfg[3]) m_ps = (m_ps >= ratio - 1) ? 0 : m_ps + 1;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (pt) m_cnt = (m_cnt + 1) % 256;
            if (ovf) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (cfg_we) m_cfg = cfg_wdata;
            m_div = (m_div + 1) % D;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
        end
        m_valid = 1;
    end

    // Per-cycle comparison, away from the edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R2 count vs model", cnt_q, m_cnt);
            check("R3 flag vs model", ovf_flag, m_flag);
            check("R9 irq vs model", irq, m_flag && irq_en);
            check("R10 cfg vs model", cfg_q, m_cfg);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        @(posedge clk); #2 cfg_we = 1; cfg_wdata = v;
        @(posedge clk); #2 cfg_we = 0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(posedge clk); #2 cnt_we = 1; cnt_wdata = v;
        @(posedge clk); #2 cnt_we = 0;
    endtask

    task automatic clr_flag();
        @(posedge clk); #2 flag_clr = 1;
        @(posedge clk); #2 flag_clr = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1; cyc(2);
            ext_in = 0; cyc(2);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 1 expected 0");
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1: reset state
        check("R1 count at reset", cnt_q, 0);
        check("R1 flag at reset", ovf_flag, 0);
        check("R1 cfg at reset", cfg_q, 8'h3F);

        // R6: latency and falling edge (reset cfg: ext, fall, bypass)
        wr_cnt(8'h00);
        ext_in = 1; cyc(4);
        check("R6 rising ignored in fall mode", cnt_q, 0);
        ext_in = 0; cyc(2);
        check("R6 no change after 2 edges", cnt_q, 0);
        cyc(1);
        check("R6 falling counted after 3 edges", cnt_q, 1);

        // R6: rising edge mode
        wr_cfg(6'b101000);
        wr_cnt(8'h00);
        pulses(5);
        check("R6 rising edges counted", cnt_q, 5);

        // R4: 1:2 and 1:8 on external pulses
        wr_cfg(6'b100000);
        wr_cnt(8'h00);
        pulses(4);
        check("R4 ratio 1:2", cnt_q, 2);
        wr_cfg(6'b100010);
        wr_cnt(8'h00);
        pulses(16);
        check("R4 ratio 1:8", cnt_q, 2);
        pulses(5);
        // R7: write clears the hidden prescaler phase
        wr_cnt(8'h10);
        pulses(7);
        check("R7 write restarted prescaler", cnt_q, 8'h10);
        pulses(1);
        check("R7 first tick after 8 events", cnt_q, 8'h11);
        check("R7 cfg unchanged by count write", cfg_q, 6'b100010);

        // R5 and R8: internal source, bypass, preload 0xFA
        wr_cfg(6'b001000);
        clr_flag();
        wr_cnt(8'hFA);
        cyc(15);
        check("R8 flag clear before 6 ticks", ovf_flag, 0);
        cyc(3);
        check("R8 flag set after 6 ticks", ovf_flag, 1);
        check("R9 irq masked", irq, 0);
        irq_en = 1; cyc(1);
        check("R9 irq asserted", irq, 1);
        cyc(30);
        check("R3 flag sticky", ovf_flag, 1);
        clr_flag();
        check("R3 flag cleared", ovf_flag, 0);
        wr_cnt(8'h00);
        cyc(30);
        check("R5 internal tick every D clocks", cnt_q, 10);

        // R3: clear held across an overflow
        wr_cnt(8'hFC);
        flag_clr = 1;
        cyc(40);
        flag_clr = 0;
        cyc(2);

        // R4 and R8: internal 1:256, preload 0xFE
        wr_cfg(6'b000111);
        clr_flag();
        wr_cnt(8'hFE);
        cyc(2 * 256 * D + 10);
        check("R8 overflow at 1:256", ovf_flag, 1);
        clr_flag();

        // R10: lowering the ratio mid-count
        wr_cnt(8'h00);
        cyc(200);
        wr_cfg(6'b000000);
        cyc(60);

        // R2: full wrap at 1:2
        clr_flag();
        wr_cnt(8'h00);
        cyc(256 * 2 * D + 20);
        check("R2 full wrap sets flag", ovf_flag, 1);

        // write during continuous ticks
        wr_cfg(6'b001000);
        wr_cnt(8'h55);
        check("R7 loaded value", cnt_q, 8'h55);
        cyc(20);
        finish_run();
    end
endmodule